// File: doc/BRIEF.md
# Watchdog Timer Peripheral

This block is a watchdog for a chip that must recover by itself when its software stops making progress. Software reaches it through a small register bank on a plain 32-bit bus: an address, a write strobe, write data, and read data that follows the address in the same cycle. Once software turns it on, a down-counter runs from a power-of-two period chosen by a 4-bit code. When the count reaches zero, the block asks for a system reset. Software holds this off by writing one fixed key value to a restart register before the period runs out.

Two range codes are held side by side. One sets the first interval after enabling. The other sets every interval after a restart. A response-mode bit chooses between two behaviours. In direct mode the first expiry resets the system. In warning mode the first expiry raises an interrupt and starts a fresh interval, and only a second expiry with no restart in between asserts the reset output. The reset output is a pulse of fixed length. No pin carries a stream of data, so the bus is a plain strobe interface with no back-pressure: every write takes effect at the clock edge where `wr_en` is high.

Register map (byte offsets): control at 0x00, range at 0x04, restart at 0x0C.

Top module: `wdog_periph`

## Requirements
- R1: After reset, the control and range registers read 0, and `irq_o` and `wdt_rst_o` are low.
- R2: Reading offset 0x00 returns the enable bit in bit 0 and the response-mode bit in bit 1. Reading 0x04 returns the 8-bit range value written there. Reading 0x0C returns 0.
- R3: A write to 0x00 with bit 0 set turns the watchdog on. After that, writes with bit 0 clear leave it on until hardware reset.
- R4: Range code c gives a period of 2^(BASE_EXP+c) cycles. Bits [3:0] of the range register give the first period. `wdt_rst_o` (direct mode) rises exactly that many cycles after the edge that enabled the block.
- R5: Writing the 32-bit value 0x76 to 0x0C while the block is enabled reloads the counter with the period of code bits [7:4]. The next expiry falls exactly that many cycles after the restart edge.
- R6: Writes to 0x0C with any other value, or while the block is disabled, leave the counter unchanged.
- R7: With mode bit 1 at 0, an expiry asserts `wdt_rst_o`.
- R8: With mode bit 1 at 1, the first expiry sets `irq_o` and reloads with the bits [7:4] period. The next expiry with no restart in between asserts `wdt_rst_o` and clears `irq_o`.
- R9: A valid restart clears `irq_o` on its edge.
- R10: `wdt_rst_o` stays high for exactly RST_CYCLES cycles and then falls.
- R11: Offsets other than 0x00, 0x04 and 0x0C read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, combinational |
| irq_o | output | 1 | Warning interrupt, high until a valid restart or the resetting expiry |
| wdt_rst_o | output | 1 | System reset request pulse |

## Verification
The embedded assertions check the rules that apply on every cycle. The enable bit never clears. A running count drops by exactly one when no load event happens. A restart always leaves the interrupt low. A warning-mode reset occurs only while an interrupt is pending. An unmapped write changes nothing, and the reset pulse starts on request and ends when its count runs out. The exact interval lengths need the bench's scenarios, which time them against writes at known edges. The same holds for choosing between the first-interval and later-interval codes, for ignoring bad keys and restarts while disabled, and for the read-back values.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CODE_W = 4;
  localparam int RANGE_W = 2 * CODE_W;
  localparam logic [31:0] OFF_CTRL = 32'h00;
  localparam logic [31:0] OFF_RANGE = 32'h04;
  localparam logic [31:0] OFF_KICK = 32'h0C;
  localparam logic [31:0] KICK_KEY = 32'h76;

  typedef struct packed {
    logic mode;
    logic en;
  } wd_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output wd_ctrl_t            ctrl_o,
  output logic [CODE_W-1:0]   init_code_o,
  output logic [CODE_W-1:0]   rest_code_o,
  output logic                start_o,
  output logic                kick_o
);
  wd_ctrl_t            ctrl_q;
  logic [RANGE_W-1:0]  range_q;
  logic hit_ctrl, hit_range, hit_kick;

  always_comb begin
    hit_ctrl  = (addr_i == ADDR_W'(OFF_CTRL));
    hit_range = (addr_i == ADDR_W'(OFF_RANGE));
    hit_kick  = (addr_i == ADDR_W'(OFF_KICK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      range_q <= '0;
    end else if (wr_en_i) begin
      if (hit_ctrl) begin
        ctrl_q.mode <= wr_data_i[1];
        if (wr_data_i[0]) ctrl_q.en <= 1'b1;
      end
      if (hit_range) range_q <= wr_data_i[RANGE_W-1:0];
    end
  end

  always_comb begin
    start_o = wr_en_i && hit_ctrl && wr_data_i[0] && !ctrl_q.en;
    kick_o  = wr_en_i && hit_kick && ctrl_q.en && (wr_data_i == DATA_W'(KICK_KEY));
    ctrl_o  = ctrl_q;
    init_code_o = range_q[CODE_W-1:0];
    rest_code_o = range_q[RANGE_W-1:CODE_W];
    if (hit_ctrl)       rd_data_o = DATA_W'(ctrl_q);
    else if (hit_range) rd_data_o = DATA_W'(range_q);
    else                rd_data_o = '0;
  end

  // R3: the enable bit cannot be cleared by software
  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |=> ctrl_q.en);
  // R11: a write that decodes to no register leaves all state untouched
  a_r11_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !hit_ctrl && !hit_range) |=> $stable({ctrl_q, range_q}));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BASE_EXP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wd_ctrl_t          ctrl_i,
  input  logic [CODE_W-1:0] init_code_i,
  input  logic [CODE_W-1:0] rest_code_i,
  input  logic              start_i,
  input  logic              kick_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int SHW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             expire;

  function automatic logic [CNT_W-1:0] period_m1(input logic [CODE_W-1:0] code);
    logic [SHW-1:0] p;
    p = SHW'(1) << (BASE_EXP + int'(code));
    return CNT_W'(p - SHW'(1));
  endfunction

  always_comb begin
    expire    = ctrl_i.en && !start_i && !kick_i && (cnt_q == '0);
    rst_req_o = expire && (!ctrl_i.mode || irq_q);
    irq_o     = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= period_m1(init_code_i);
    end else if (kick_i) begin
      cnt_q <= period_m1(rest_code_i);
      irq_q <= 1'b0;
    end else if (expire) begin
      cnt_q <= period_m1(rest_code_i);
      irq_q <= ctrl_i.mode && !irq_q;
    end else if (ctrl_i.en) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R4: a running count falls by one per cycle when nothing reloads it
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.en && !start_i && !kick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R9: a valid restart leaves the interrupt low
  a_r9_kick_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !irq_o);
  // R8: in warning mode a reset request needs a pending interrupt
  a_r8_warn_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && ctrl_i.mode) |-> irq_q);
endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rst_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (req_i)          cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign rst_o = (cnt_q != '0);

  // R10: a request starts the pulse on the next cycle
  a_r10_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rst_o);
  // R10: the pulse ends when its count is spent
  a_r10_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_o && !req_i && cnt_q == CW'(1)) |=> !rst_o);
endmodule

// File: rtl/wdog_periph.sv
module wdog_periph
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 32,
  parameter int BASE_EXP = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  wd_ctrl_t          ctrl;
  logic [CODE_W-1:0] init_code, rest_code;
  logic              start, kick, rst_req;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ctrl_o(ctrl), .init_code_o(init_code),
    .rest_code_o(rest_code), .start_o(start), .kick_o(kick)
  );

  wdog_counter #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) cnt_i (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .init_code_i(init_code),
    .rest_code_i(rest_code), .start_i(start), .kick_i(kick),
    .irq_o(irq_o), .rst_req_o(rst_req)
  );

  wdog_rst_stretch #(.RST_CYCLES(RST_CYCLES)) pulse_i (
    .clk(clk), .rst_n(rst_n), .req_i(rst_req), .rst_o(wdt_rst_o)
  );

  // R7: in direct mode every expiry request becomes a reset pulse
  a_r7_direct_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !ctrl.mode) |=> wdt_rst_o);
endmodule

// File: tb/wdog_periph_tb_top.sv
module wdog_periph_tb_top;
  localparam int BASE = 4;
  localparam int RSTC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq, wrst;

  always #4 clk = ~clk;

  wdog_periph #(.BASE_EXP(BASE), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_o(irq), .wdt_rst_o(wrst)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  rst;
    logic  irq;
    string tag;
  } exp_t;
  exp_t q[$];
  exp_t it;

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic expect_at(int at, logic r, logic i, string tag);
    q.push_back('{at, r, i, tag});
  endtask

  // monitor: pops scheduled expectations and compares the outputs
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      it = q.pop_front();
      if (it.at < cyc) begin
        checks++; errors++;
        $display("FAIL %s missed sample actual=%0d expected=%0d", it.tag, cyc, it.at);
      end else begin
        check({it.tag, " rst"}, {31'b0, wrst}, {31'b0, it.rst});
        check({it.tag, " irq"}, {31'b0, irq}, {31'b0, it.irq});
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d, output int at);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    at = cyc;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] expv, string tag);
    addr = a;
    #1;
    check(tag, rd_data, expv);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic wait_until(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic do_reset();
    drain();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog timeout actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w, k, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(8'h00, 32'h0, "R1 ctrl after reset");
    rd(8'h04, 32'h0, "R1 range after reset");
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 rst after reset", {31'b0, wrst}, 32'h0);

    // R6: restart while disabled does nothing, no expiry ever comes
    wr(8'h0C, 32'h76, t);
    expect_at(t + 40, 1'b0, 1'b0, "R6 kick while disabled");
    drain();
    rd(8'h00, 32'h0, "R6 still disabled");

    // R2/R11: read-back and unmapped offsets
    wr(8'h04, 32'h5A, t);
    wr(8'h08, 32'hFFFF_FFFF, t);
    wr(8'h10, 32'h3, t);
    rd(8'h04, 32'h5A, "R2 range readback");
    rd(8'h0C, 32'h0, "R2 restart reads zero");
    rd(8'h08, 32'h0, "R11 unmapped 0x08");
    rd(8'h10, 32'h0, "R11 unmapped 0x10");
    rd(8'h00, 32'h0, "R11 ctrl untouched");
    wr(8'h00, 32'h2, t);
    rd(8'h00, 32'h2, "R2 mode bit readback");

    // R4/R7/R10/R3/R6: direct mode, first period from code 1 (32 cycles)
    do_reset();
    wr(8'h04, 32'h21, t);
    wr(8'h00, 32'h1, w);
    expect_at(w + 31, 1'b0, 1'b0, "R4 before first expiry");
    expect_at(w + 32, 1'b1, 1'b0, "R7 reset on expiry");
    expect_at(w + 39, 1'b1, 1'b0, "R10 pulse held");
    expect_at(w + 40, 1'b0, 1'b0, "R10 pulse released");
    rd(8'h00, 32'h1, "R2 enable readback");
    wr(8'h00, 32'h0, t);
    rd(8'h00, 32'h1, "R3 enable sticky");
    wr(8'h0C, 32'h75, t);
    wr(8'h0C, 32'h176, t);
    drain();

    // R5: restart reloads with code 2 (64 cycles)
    do_reset();
    wr(8'h04, 32'h21, t);
    wr(8'h00, 32'h1, w);
    wait_until(w + 18);
    wr(8'h0C, 32'h76, k);
    expect_at(w + 32, 1'b0, 1'b0, "R5 no expiry after restart");
    expect_at(k + 63, 1'b0, 1'b0, "R5 before reloaded expiry");
    expect_at(k + 64, 1'b1, 1'b0, "R5 expiry after later period");
    expect_at(k + 64 + RSTC, 1'b0, 1'b0, "R10 release after restart");
    drain();

    // R8: warning mode, first 16 cycles then 32
    do_reset();
    wr(8'h04, 32'h10, t);
    wr(8'h00, 32'h3, w);
    expect_at(w + 15, 1'b0, 1'b0, "R8 before first expiry");
    expect_at(w + 16, 1'b0, 1'b1, "R8 interrupt on first expiry");
    expect_at(w + 47, 1'b0, 1'b1, "R8 interrupt held");
    expect_at(w + 48, 1'b1, 1'b0, "R8 reset on second expiry");
    drain();

    // R9: restart clears the interrupt and defers the reset
    do_reset();
    wr(8'h04, 32'h10, t);
    wr(8'h00, 32'h3, w);
    expect_at(w + 16, 1'b0, 1'b1, "R9 interrupt raised");
    wait_until(w + 20);
    wr(8'h0C, 32'h76, k);
    check("R9 restart clears irq", {31'b0, irq}, 32'h0);
    expect_at(k + 31, 1'b0, 1'b0, "R9 quiet after restart");
    expect_at(k + 32, 1'b0, 1'b1, "R9 warning again not reset");
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule